// File: doc/BRIEF.md
# Fully Associative Word Cache

This block is a four-entry, load-only cache placed between a processor request port and a word-wide memory port. Each entry holds one 32-bit word, a valid flag and a 30-bit word-address tag. There is no index field. Every request address is compared against all resident tags at once, so each entry has its own comparator, and any word may sit in any entry.

A hit returns the stored word combinationally in the cycle the request is presented. On a miss, the processor request is held off. The block issues the word-aligned address on the memory request handshake and waits for the memory's response word. It writes that word and its tag into a victim entry, then returns the word to the processor in the following cycle. The processor keeps its request and address stable until it sees the request accepted.

Top module: `fa_word_cache`

## Requirements
- R1: After reset every entry is invalid, the victim pointer is at entry 0, and `cpu_req_ready_o`, `cpu_rsp_valid_o` and `mem_req_valid_o` are low.
- R2: When a valid request matches a valid tag, `cpu_req_ready_o` and `cpu_rsp_valid_o` are high in that same cycle, `cpu_rsp_data_o` is the stored word, and no memory request is made.
- R3: On a miss, `cpu_req_ready_o` stays low from the request until the refill word is returned. `mem_addr_o` equals the request address with bits [1:0] forced to 0.
- R4: The cycle after memory delivers the word (`mem_rsp_valid_i` high while waiting), `cpu_rsp_valid_o` and `cpu_req_ready_o` are high together and `cpu_rsp_data_o` equals the delivered word. Later requests to that word hit and return it.
- R5: Address bits [1:0] take no part in the tag, so byte addresses within the same word hit the same entry.
- R6: An invalid entry never hits, even when its stored tag equals address bits [31:2]. After reset, address 0 misses.
- R7: While any entry is invalid, a miss fills the invalid entry with the lowest index.
- R8: When all entries are valid, a miss replaces the entry named by a round-robin pointer. The pointer advances by one, modulo 4, after every refill, including refills into invalid entries.
- R9: `mem_req_valid_o` stays high and `mem_addr_o` stays stable until `mem_req_ready_i` is sampled high.
- R10: All 30 tag bits are compared, so two addresses that differ only in bits [31:30] are different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_valid_i | input | 1 | Processor load request valid |
| cpu_req_ready_o | output | 1 | Request accepted this cycle |
| cpu_addr_i | input | 32 | Processor byte address |
| cpu_rsp_valid_o | output | 1 | Load data valid |
| cpu_rsp_data_o | output | 32 | Load data |
| mem_req_valid_o | output | 1 | Refill request valid |
| mem_req_ready_i | input | 1 | Memory accepts refill request |
| mem_addr_o | output | 32 | Word-aligned refill address |
| mem_rsp_valid_i | input | 1 | Refill word valid |
| mem_rsp_data_i | input | 32 | Refill word |

## Verification
On every cycle, the assertions check the following local rules:
- at most one entry matches an address;
- the refill request stays stable and word-aligned while it waits for acceptance;
- the processor is never told ready while a refill request is outstanding;
- a response always comes with acceptance;
- valid flags never clear outside reset.

Which entry a miss evicts can only be seen through the bench's scenarios, as can the order of round-robin replacement after cold fills and whether returned data is the most recent refill. Those scenarios compare data and hit/miss outcomes against a reference model of tags, valid flags and pointer.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MREQ = 2'd1,
    ST_MWAIT = 2'd2,
    ST_RESP = 2'd3
  } fill_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int ENTRIES = 4,
  parameter int TAG_W = 30,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [TAG_W-1:0]              tag_i,
  output logic [ENTRIES-1:0]            hit_vec_o,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              hit_idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               advance_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q;

  // lowest-index invalid entry wins, pointer otherwise
  always_comb begin
    victim_o = rr_q;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) victim_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (advance_i) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/fa_word_cache.sv
module fa_word_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_rsp_valid_o,
  output logic [DATA_W-1:0] cpu_rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  fill_state_e state_q, state_d;

  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [TAG_W-1:0]               miss_tag_q;
  logic [DATA_W-1:0]              rsp_q;

  logic [ENTRIES-1:0] hit_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim;
  logic               refill;
  logic [TAG_W-1:0]   req_tag;

  assign req_tag = cpu_addr_i[ADDR_W-1:OFF_W];

  fa_tag_match #(
    .ENTRIES(ENTRIES),
    .TAG_W  (TAG_W)
  ) u_match (
    .tags_i   (tag_q),
    .valid_i  (valid_q),
    .tag_i    (req_tag),
    .hit_vec_o(hit_vec),
    .hit_o    (hit),
    .hit_idx_o(hit_idx)
  );

  assign refill = (state_q == ST_MWAIT) && mem_rsp_valid_i;

  fa_victim_sel #(
    .ENTRIES(ENTRIES)
  ) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .advance_i(refill),
    .victim_o (victim)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cpu_req_valid_i && !hit) state_d = ST_MREQ;
      ST_MREQ:  if (mem_req_ready_i) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid_i) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      miss_tag_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req_valid_i && !hit) miss_tag_q <= req_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
      rsp_q   <= '0;
    end else if (refill) begin
      valid_q[victim] <= 1'b1;
      tag_q[victim]   <= miss_tag_q;
      data_q[victim]  <= mem_rsp_data_i;
      rsp_q           <= mem_rsp_data_i;
    end
  end

  logic idle_hit;
  assign idle_hit = (state_q == ST_IDLE) && cpu_req_valid_i && hit;

  assign cpu_req_ready_o = idle_hit || (state_q == ST_RESP);
  assign cpu_rsp_valid_o = idle_hit || (state_q == ST_RESP);
  assign cpu_rsp_data_o  = (state_q == ST_RESP) ? rsp_q : data_q[hit_idx];
  assign mem_req_valid_o = (state_q == ST_MREQ);
  assign mem_addr_o      = {miss_tag_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/fa_word_cache_chk.sv
module fa_word_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int ENTRIES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpu_req_ready_o,
  input logic               cpu_rsp_valid_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_q
);
  // R2, R5, R10: a tag lives in at most one entry
  a_r2_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  a_r3_aligned_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_addr_o[1:0] == 2'b00));

  a_r3_no_ready_in_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (!cpu_req_ready_o && !cpu_rsp_valid_o));

  a_r4_rsp_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rsp_valid_o |-> cpu_req_ready_o);

  a_r9_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  a_r7_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(valid_q) >= $countones($past(valid_q))));
endmodule

bind fa_word_cache fa_word_cache_chk #(
  .ADDR_W (ADDR_W),
  .ENTRIES(ENTRIES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_req_ready_o(cpu_req_ready_o),
  .cpu_rsp_valid_o(cpu_rsp_valid_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_addr_o     (mem_addr_o),
  .hit_vec        (hit_vec),
  .valid_q        (valid_q)
);

// File: tb/fa_word_cache_test.sv
module fa_word_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        cpu_req_ready, cpu_rsp_valid, mem_req_valid;
  logic [31:0] cpu_rsp_data, mem_addr;

  always #5 clk = ~clk;

  fa_word_cache uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cpu_req_valid_i(cpu_req_valid),
    .cpu_req_ready_o(cpu_req_ready),
    .cpu_addr_i     (cpu_addr),
    .cpu_rsp_valid_o(cpu_rsp_valid),
    .cpu_rsp_data_o (cpu_rsp_data),
    .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_req_ready),
    .mem_addr_o     (mem_addr),
    .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i (mem_rsp_data)
  );

  int checks = 0;
  int fails = 0;
  int fetch_cnt = 0;
  int fetch_seen = 0;
  int model_fetch = 0;

  logic [31:0] exp_data_q[$];
  bit          exp_miss_q[$];
  string       exp_req_q[$];

  bit          m_valid[4];
  logic [29:0] m_tag[4];
  logic [31:0] m_data[4];
  int          m_rr = 0;

  function automatic logic [31:0] mem_word(logic [31:0] a, int n);
    return {a[31:2], 2'b00} ^ 32'h5A3C_0F00 ^ (32'(n) * 32'h0101_0107);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: predicts, pushes expectation, drives one load
  task automatic access(logic [31:0] a, string req);
    bit hit = 0;
    int idx = 0;
    int v = -1;
    logic [31:0] d;
    int waited = 0;
    for (int i = 0; i < 4; i++)
      if (m_valid[i] && m_tag[i] == a[31:2]) begin hit = 1; idx = i; end
    if (hit) d = m_data[idx];
    else begin
      for (int i = 3; i >= 0; i--) if (!m_valid[i]) v = i;
      if (v < 0) v = m_rr;
      m_rr = (m_rr + 1) % 4;
      d = mem_word(a, model_fetch);
      model_fetch++;
      m_valid[v] = 1; m_tag[v] = a[31:2]; m_data[v] = d;
    end
    exp_data_q.push_back(d);
    exp_miss_q.push_back(!hit);
    exp_req_q.push_back(req);
    @(posedge clk); #2;
    cpu_req_valid = 1'b1;
    cpu_addr = a;
    @(negedge clk);
    // R2 / R3: ready in first cycle only for a hit
    check(cpu_req_ready == hit, hit ? "R2" : "R3", "first-cycle ready", 32'(cpu_req_ready), 32'(hit));
    while (!cpu_req_ready) begin
      @(negedge clk);
      waited++;
    end
    @(posedge clk); #2;
    cpu_req_valid = 1'b0;
  endtask

  // monitor: pops expectations as responses appear
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid) begin
      if (exp_data_q.size() == 0) begin
        check(0, "R2", "unexpected response", cpu_rsp_data, '0);
      end else begin
        logic [31:0] ed;
        bit em;
        string rq;
        ed = exp_data_q.pop_front();
        em = exp_miss_q.pop_front();
        rq = exp_req_q.pop_front();
        check(cpu_rsp_data == ed, rq, "data", cpu_rsp_data, ed);
        check((fetch_cnt != fetch_seen) == em, rq, "miss flag", 32'(fetch_cnt != fetch_seen), 32'(em));
        check(cpu_req_ready, "R4", "ready with response", 32'(cpu_req_ready), 32'd1);
        fetch_seen = fetch_cnt;
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [31:0] a;
        a = mem_addr;
        check(a == {cpu_addr[31:2], 2'b00}, "R3", "refill address", a, {cpu_addr[31:2], 2'b00});
        repeat (fetch_cnt % 3) begin
          @(negedge clk);
          check(mem_req_valid && mem_addr == a, "R9", "request held", mem_addr, a);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (fetch_cnt % 2) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_word(a, fetch_cnt);
        fetch_cnt++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    check(!cpu_req_ready && !cpu_rsp_valid && !mem_req_valid, "R1", "reset outputs",
          {29'd0, cpu_req_ready, cpu_rsp_valid, mem_req_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req_valid && !cpu_rsp_valid, "R1", "idle after reset", 32'(mem_req_valid), '0);

    access(32'h0000_0000, "R6");   // invalid entry with tag 0 must miss
    access(32'h0000_0002, "R5");   // same word, other byte offset
    access(32'h0000_0003, "R5");
    access(32'h0000_0100, "R7");
    access(32'h0000_0204, "R7");
    access(32'h0000_030C, "R7");
    access(32'h0000_0101, "R2");
    access(32'h0000_0206, "R2");
    access(32'h0000_030F, "R2");
    access(32'h0000_0000, "R2");
    access(32'h4000_0000, "R10");  // upper-bit difference: pointer evicts entry 0
    access(32'h4000_0000, "R4");
    access(32'h0000_0000, "R8");   // evicts entry 1 (0x100)
    access(32'h0000_0204, "R8");
    access(32'h0000_0100, "R8");   // evicts entry 2 (0x204)
    access(32'h0000_0204, "R8");
    access(32'hC000_0000, "R10");
    access(32'h8000_0000, "R10");

    for (int k = 0; k < 30; k++) begin
      logic [31:0] a;
      a = {2'(k % 3), 20'd0, 8'(((k * 7) % 5) * 4), 2'(k % 4)};
      access(a, "R8");
    end

    repeat (4) @(negedge clk);
    check(exp_data_q.size() == 0, "R4", "all responses seen", exp_data_q.size(), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule